// File: doc/BRIEF.md
# Three-Phase Stateful NOR Cell

This block is a cycle-accurate logical model of a NOR gate whose result is held in a storage bit instead of being produced by combinational gating. It keeps one stored bit per input plus a result bit. Each operation takes three strobes in turn. A load strobe captures the input word and clears the result bit in the same cycle. A compute strobe lets the result bit move from 0 to 1, but only when every stored input is 0. A fetch strobe copies the result bit to a registered output and marks it valid for one cycle.

Setting the parameter `DUAL_RESULT` gives the cell two result bits that are used in turn. Compute switches operations to the other bit. The following load clears that other bit, and it may share a cycle with the fetch of the previous result. A steady stream then needs two cycles per operation instead of three. A strobe that arrives out of order, or an illegal mix of strobes in one cycle, changes no state, and the cell pulses an error flag. The input count `FANIN` may be 1, 2 or 3.

Top module: `nor_phase_cell`

## Requirements
- R1: After reset, `res_out`, `res_vld` and `seq_err` are all 0.
- R2: A load of word D, then a compute, then a fetch gives `res_out` = 1 when every bit of D is 0 and `res_out` = 0 otherwise. The result is visible in the cycle after the fetch strobe.
- R3: `res_vld` is high for exactly one cycle after each accepted fetch. `res_out` changes only in that cycle and holds its value at all other times.
- R4: Only a load can clear the result bit. Compute can only set it from 0 to 1. A result of 1 followed by a full operation on a nonzero word therefore reads 0.
- R5: A compute with no pending load, or a fetch with no computed result waiting, is ignored. It raises `seq_err` for one cycle in the next cycle, and `res_vld` stays 0.
- R6: Some strobe combinations in one cycle are illegal. These are compute together with any other strobe, and in single-result mode load together with fetch. On any of them, every strobe of that cycle is ignored and `seq_err` pulses.
- R7: With `DUAL_RESULT`=1, a load and a fetch in the same cycle are both accepted. The sequence load, compute, then repeated load+fetch, compute, gives results in order at two cycles per operation.
- R8: In single-result mode, a load while a result is still unread is ignored and raises `seq_err`. A later fetch returns the earlier result.
- R9: With `DUAL_RESULT`=1, a compute while a result is still unread is ignored and raises `seq_err`. After that result is fetched, the same loaded word can be computed and fetched.
- R10: Elaboration fails when `FANIN` is outside the range 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe: capture the input word and clear the active result bit |
| ld_data | input | FANIN | Input word captured on load |
| cmp_en | input | 1 | Compute strobe |
| fetch_en | input | 1 | Fetch strobe |
| res_out | output | 1 | Registered result bit |
| res_vld | output | 1 | One-cycle flag marking a new result on `res_out` |
| seq_err | output | 1 | One-cycle flag marking an ignored strobe |

## Verification
A wrong internal state shows up at the ports at the next fetch. A missed clear or a wrong set of the result bit gives an inverted `res_out` one cycle after the fetch strobe. A wrong load or pending flag shows up in the next cycle, either as a `seq_err` pulse on a legal strobe or as no pulse on an illegal one. A wrong result-bit selector in dual mode shows up as results coming out of order during the overlapped load-and-fetch stream.

// File: rtl/nor_phase_cell.sv
module nor_phase_cell #(
  parameter int FANIN       = 3,
  parameter bit DUAL_RESULT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [FANIN-1:0] ld_data,
  input  logic             cmp_en,
  input  logic             fetch_en,
  output logic             res_out,
  output logic             res_vld,
  output logic             seq_err
);
  localparam int NBANK = DUAL_RESULT ? 2 : 1;

  // R10: the fan-in is limited at elaboration
  if (FANIN < 1 || FANIN > 3) begin : g_fanin_bad
    $error("nor_phase_cell: FANIN must be 1..3");
  end

  logic [FANIN-1:0] in_q;
  logic [NBANK-1:0] ev_q;
  logic loaded, pend, act, rsel;

  wire ld_ok  = ld_en && !loaded && (DUAL_RESULT || !pend);
  wire cmp_ok = cmp_en && loaded && !pend;
  wire fch_ok = fetch_en && pend;
  wire multi  = (ld_en && cmp_en) || (cmp_en && fetch_en) ||
                (ld_en && fetch_en && !DUAL_RESULT);
  wire bad    = (ld_en && !ld_ok) || (cmp_en && !cmp_ok) ||
                (fetch_en && !fch_ok) || multi;
  wire do_ld  = ld_en && !bad;
  wire do_cmp = cmp_en && !bad;
  wire do_fch = fetch_en && !bad;
  wire all_lo = ~|in_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                ev_q[b] <= 1'b0;
      else if (do_ld && act == 1'(b))            ev_q[b] <= 1'b0;
      else if (do_cmp && act == 1'(b) && all_lo) ev_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= '0;
      loaded  <= 1'b0;
      pend    <= 1'b0;
      act     <= 1'b0;
      rsel    <= 1'b0;
      res_out <= 1'b0;
      res_vld <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      seq_err <= bad;
      res_vld <= do_fch;
      if (do_ld) begin
        in_q   <= ld_data;
        loaded <= 1'b1;
      end
      if (do_cmp) begin
        loaded <= 1'b0;
        pend   <= 1'b1;
        rsel   <= act;
        if (DUAL_RESULT) act <= ~act;
      end
      if (do_fch) begin
        pend    <= 1'b0;
        res_out <= ev_q[rsel];
      end
    end
  end
endmodule

// File: rtl/nor_phase_cell_chk.sv
module nor_phase_cell_chk #(
  parameter bit DUAL_RESULT = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic ld_en,
  input logic cmp_en,
  input logic fetch_en,
  input logic res_out,
  input logic res_vld,
  input logic seq_err
);
  a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res_out));
  a_r3_vld_from_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(fetch_en));
  a_r5_err_no_vld: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !res_vld);
  a_r6_cmp_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && (ld_en || fetch_en)) |=> (seq_err && !res_vld));
  a_r6_single_ld_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!DUAL_RESULT && ld_en && fetch_en) |=> seq_err);
endmodule

bind nor_phase_cell nor_phase_cell_chk #(.DUAL_RESULT(DUAL_RESULT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .cmp_en(cmp_en),
  .fetch_en(fetch_en), .res_out(res_out), .res_vld(res_vld),
  .seq_err(seq_err)
);

// File: tb/nor_phase_cell_test.sv
`timescale 1ns/1ps
module nor_phase_cell_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       s_ld = 0, s_cmp = 0, s_fch = 0;
  logic [2:0] s_d = '0;
  logic       s_out, s_vld, s_err;
  logic       a_ld = 0, a_cmp = 0, a_fch = 0;
  logic [2:0] a_d = '0;
  logic       a_out, a_vld, a_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  nor_phase_cell #(.FANIN(3), .DUAL_RESULT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .ld_en(s_ld), .ld_data(s_d), .cmp_en(s_cmp),
    .fetch_en(s_fch), .res_out(s_out), .res_vld(s_vld), .seq_err(s_err));

  nor_phase_cell #(.FANIN(3), .DUAL_RESULT(1'b1)) uut_alt (
    .clk(clk), .rst_n(rst_n), .ld_en(a_ld), .ld_data(a_d), .cmp_en(a_cmp),
    .fetch_en(a_fch), .res_out(a_out), .res_vld(a_vld), .seq_err(a_err));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic s_step(input logic l, input logic [2:0] d, input logic c, input logic f);
    s_ld = l; s_d = d; s_cmp = c; s_fch = f;
    @(posedge clk); #1;
    s_ld = 0; s_cmp = 0; s_fch = 0;
  endtask

  task automatic a_step(input logic l, input logic [2:0] d, input logic c, input logic f);
    a_ld = l; a_d = d; a_cmp = c; a_fch = f;
    @(posedge clk); #1;
    a_ld = 0; a_cmp = 0; a_fch = 0;
  endtask

  task automatic t_reset;
    chk("R1 res_out", s_out, 1'b0);
    chk("R1 res_vld", s_vld, 1'b0);
    chk("R1 seq_err", s_err, 1'b0);
    chk("R1 alt res_vld", a_vld, 1'b0);
  endtask

  task automatic t_nor_all;
    for (int v = 0; v < 8; v++) begin
      s_step(1, 3'(v), 0, 0);
      s_step(0, 0, 1, 0);
      chk("R2 no err on compute", s_err, 1'b0);
      s_step(0, 0, 0, 1);
      chk("R2 result", s_out, (v == 0));
      chk("R3 vld on fetch", s_vld, 1'b1);
      s_step(0, 0, 0, 0);
      chk("R3 vld one cycle", s_vld, 1'b0);
      chk("R3 result held", s_out, (v == 0));
    end
  endtask

  task automatic t_oneway;
    s_step(1, 3'b000, 0, 0); s_step(0, 0, 1, 0); s_step(0, 0, 0, 1);
    chk("R4 first result 1", s_out, 1'b1);
    s_step(1, 3'b100, 0, 0); s_step(0, 0, 1, 0); s_step(0, 0, 0, 1);
    chk("R4 load cleared result", s_out, 1'b0);
  endtask

  task automatic t_order;
    s_step(0, 0, 1, 0);
    chk("R5 compute w/o load err", s_err, 1'b1);
    s_step(0, 0, 0, 1);
    chk("R5 fetch w/o result err", s_err, 1'b1);
    chk("R5 fetch w/o result no vld", s_vld, 1'b0);
    s_step(1, 3'b000, 0, 0); s_step(0, 0, 1, 0); s_step(0, 0, 0, 1);
    chk("R5 recovers", s_out, 1'b1);
    chk("R5 recovers vld", s_vld, 1'b1);
  endtask

  task automatic t_conflict;
    s_step(1, 3'b010, 0, 0);
    s_step(0, 0, 1, 1);
    chk("R6 compute+fetch err", s_err, 1'b1);
    s_step(0, 0, 1, 0);
    chk("R6 load kept, compute ok", s_err, 1'b0);
    s_step(0, 0, 0, 1);
    chk("R6 result after conflict", s_out, 1'b0);
    s_step(1, 3'b000, 1, 0);
    chk("R6 load+compute err", s_err, 1'b1);
    s_step(0, 0, 1, 0);
    chk("R6 load was ignored", s_err, 1'b1);
    s_step(1, 3'b000, 0, 0); s_step(0, 0, 1, 0);
    s_step(1, 3'b000, 0, 1);
    chk("R6 single load+fetch err", s_err, 1'b1);
    chk("R6 single load+fetch no vld", s_vld, 1'b0);
    s_step(0, 0, 0, 1);
    chk("R6 fetch after conflict", s_out, 1'b1);
  endtask

  task automatic t_pending;
    s_step(1, 3'b000, 0, 0); s_step(0, 0, 1, 0);
    s_step(1, 3'b101, 0, 0);
    chk("R8 load over pending err", s_err, 1'b1);
    s_step(0, 0, 0, 1);
    chk("R8 old result kept", s_out, 1'b1);
    chk("R8 vld", s_vld, 1'b1);
  endtask

  task automatic t_alt_pipe;
    a_step(1, 3'b000, 0, 0);
    a_step(0, 0, 1, 0);
    a_step(1, 3'b011, 0, 1);
    chk("R7 overlap no err", a_err, 1'b0);
    chk("R7 first result", a_out, 1'b1);
    chk("R7 first vld", a_vld, 1'b1);
    a_step(0, 0, 1, 0);
    a_step(1, 3'b000, 0, 1);
    chk("R7 second result", a_out, 1'b0);
    chk("R7 second no err", a_err, 1'b0);
    a_step(0, 0, 1, 0);
    a_step(0, 0, 0, 1);
    chk("R7 third result", a_out, 1'b1);
    chk("R7 third vld", a_vld, 1'b1);
  endtask

  task automatic t_alt_cmp_pending;
    a_step(1, 3'b000, 0, 0); a_step(0, 0, 1, 0);
    a_step(1, 3'b111, 0, 0);
    chk("R9 load into other bit ok", a_err, 1'b0);
    a_step(0, 0, 1, 0);
    chk("R9 compute over pending err", a_err, 1'b1);
    a_step(0, 0, 0, 1);
    chk("R9 pending result", a_out, 1'b1);
    a_step(0, 0, 1, 0);
    chk("R9 compute accepted", a_err, 1'b0);
    a_step(0, 0, 0, 1);
    chk("R9 later result", a_out, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_nor_all;
    t_oneway;
    t_order;
    t_conflict;
    t_pending;
    t_alt_pipe;
    t_alt_cmp_pending;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule